// File: doc/BRIEF.md
# Control Response Rate Selector

The block chooses the rate at which a station answers a received frame with a control response. It takes the rate index of the received frame and a 12-bit bitmap of the basic rates in force, and searches downward from the received rate for a rate that is also basic. Slow (CCK) requests and fast (OFDM) requests are searched within their own groups. Each group has its own fallback when no basic rate is found. An OFDM response also carries an 8-bit signal rate code and an 8-bit reserve time, and both depend on whether the link is in the 5 GHz or the 2.4 GHz band.

From the same bitmap the block also reports the highest basic CCK rate, the highest basic OFDM rate and whether any OFDM rate is basic. A request is presented with a one-cycle valid strobe. All results appear together on registered outputs in the next cycle, and they hold until the next request. Requests may be issued back to back, one per cycle.

Rate indices are 0 to 3 for 1, 2, 5.5 and 11 Mb/s. Indices 4 to 11 are 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s. Bit i of the bitmap marks index i as basic.

Top module: `rsp_rate_picker`

## Requirements
- R1: One clock edge after an edge that samples reqValid high, rspValid is high and every result output reflects that request. rspValid is low after an edge that samples reqValid low, and the result outputs then keep their previous values.
- R2: While rstN is low, every output is zero.
- R3: A request with index 0 to 3 returns the highest index j, 1 <= j <= request, whose bitmap bit is set. If no such bit is set, it returns 0.
- R4: When bitmap bits 4 to 11 are all clear, a request with index 4 to 11 returns the request index clamped to at most 8 (24 Mb/s).
- R5: When any of bitmap bits 4 to 11 is set, a request with index 4 to 11 returns the highest index j, 4 <= j <= request, whose bit is set. If no such bit is set, it returns 8, even when 8 exceeds the request.
- R6: A request index of 12 to 15 behaves exactly like index 11.
- R7: For a response index of 4 to 11, sigCode has the low nibble B, F, A, E, 9, D, 8, C in index order. Its high nibble is 9 when band5g=1 (5 GHz) and 8 when band5g=0 (2.4 GHz).
- R8: For a response index of 4 to 11, rsvTime is 44, 36, 32, 28, 28, 24, 24, 24 in index order when band5g=1, and each value plus 6 when band5g=0.
- R9: For a response index of 0 to 3, sigCode and rsvTime are both 0.
- R10: topOfdm is the highest set bitmap bit among 4 to 11, or 8 when none is set. topCck is the highest set bit among 0 to 3, or 0 when none is set. anyOfdm is 1 exactly when some bit in 4 to 11 is set. All three are captured with the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqRate | input | 4 | Rate index of the received frame |
| basicMap | input | 12 | Basic-rate bitmap, bit i for index i |
| band5g | input | 1 | 1 = 5 GHz band, 0 = 2.4 GHz band |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspRate | output | 4 | Chosen response rate index |
| sigCode | output | 8 | Signal rate code for an OFDM response, else 0 |
| rsvTime | output | 8 | Reserve time in microseconds for an OFDM response, else 0 |
| topCck | output | 4 | Highest basic CCK index |
| topOfdm | output | 4 | Highest basic OFDM index |
| anyOfdm | output | 1 | Some OFDM rate is basic |

## Verification
On every cycle the assertions check several properties. The strobe timing must hold, and the results must stay put between requests. A CCK request must never be answered with an OFDM rate, and an OFDM request never with a CCK rate. A found CCK rate must be a basic one, and the band nibble of the signal code must match the band. The exact chosen rate under each fallback rule, the per-rate codes and reserve times, and the reported top rates come only from the bench. It sweeps every bitmap against every index in both bands and runs directed cases for indices above 11 and fallbacks that rise above the request.

// File: rtl/rsp_rate_pkg.sv
package rsp_rate_pkg;
  localparam int RATE_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              ofdmReq;
    logic [RATE_W-1:0] startIdx;
  } rateStrobe_t;

  // low nibble of the signal code, by OFDM offset 0..7
  function automatic logic [3:0] codeNibble(input logic [2:0] ofs);
    case (ofs)
      3'd0: codeNibble = 4'hB;
      3'd1: codeNibble = 4'hF;
      3'd2: codeNibble = 4'hA;
      3'd3: codeNibble = 4'hE;
      3'd5: codeNibble = 4'hD;
      3'd6: codeNibble = 4'h8;
      3'd7: codeNibble = 4'hC;
      default: codeNibble = 4'h9;
    endcase
  endfunction

  // 5 GHz reserve time in microseconds, by OFDM offset 0..7
  function automatic logic [7:0] rsvBase(input logic [2:0] ofs);
    case (ofs)
      3'd0: rsvBase = 8'd44;
      3'd1: rsvBase = 8'd36;
      3'd2: rsvBase = 8'd32;
      3'd3: rsvBase = 8'd28;
      3'd5, 3'd6, 3'd7: rsvBase = 8'd24;
      default: rsvBase = 8'd28;
    endcase
  endfunction
endpackage

// File: rtl/rsp_rate_enc.sv
module rsp_rate_enc
  import rsp_rate_pkg::*;
#(
  parameter int NUM_CCK   = 4,
  parameter int NUM_RATES = 12,
  parameter int FALLBACK  = 8,
  parameter int BAND_ADD  = 6
) (
  input  logic [RATE_W-1:0] rateIdx,
  input  logic              band5g,
  output logic [7:0]        code,
  output logic [7:0]        rsv
);
  localparam logic [RATE_W-1:0] FB_IDX = RATE_W'(FALLBACK);
  localparam logic [RATE_W-1:0] CCK_N  = RATE_W'(NUM_CCK);
  localparam logic [RATE_W-1:0] TOP_N  = RATE_W'(NUM_RATES - 1);

  logic [RATE_W-1:0] useIdx;
  logic [RATE_W-1:0] ofsFull;
  logic [2:0]        ofs;

  // an index outside the OFDM group encodes as the fallback rate
  always_comb begin
    if (rateIdx < CCK_N || rateIdx > TOP_N) useIdx = FB_IDX;
    else                                    useIdx = rateIdx;
    ofsFull = useIdx - CCK_N;
    ofs     = ofsFull[2:0];
  end

  always_comb begin
    code = {(band5g ? 4'h9 : 4'h8), codeNibble(ofs)};
    rsv  = rsvBase(ofs) + (band5g ? 8'd0 : 8'(BAND_ADD));
  end

  logic unusedHi;
  assign unusedHi = ^ofsFull[RATE_W-1:3];
endmodule

// File: rtl/rsp_rate_ctrl.sv
module rsp_rate_ctrl
  import rsp_rate_pkg::*;
#(
  parameter int NUM_CCK   = 4,
  parameter int NUM_RATES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RATE_W-1:0] reqRate,
  output rateStrobe_t       strobe,
  output logic              rspValid
);
  localparam logic [RATE_W-1:0] TOP_N = RATE_W'(NUM_RATES - 1);
  localparam logic [RATE_W-1:0] CCK_N = RATE_W'(NUM_CCK);

  logic [RATE_W-1:0] clampIdx;

  // indices beyond the table are searched as the top rate
  always_comb begin
    clampIdx        = (reqRate > TOP_N) ? TOP_N : reqRate;
    strobe.capture  = reqValid;
    strobe.startIdx = clampIdx;
    strobe.ofdmReq  = (clampIdx >= CCK_N);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/rsp_rate_dp.sv
module rsp_rate_dp
  import rsp_rate_pkg::*;
#(
  parameter int NUM_CCK   = 4,
  parameter int NUM_RATES = 12,
  parameter int FALLBACK  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rateStrobe_t          strobe,
  input  logic [NUM_RATES-1:0] basicMap,
  input  logic                 band5g,
  output logic [RATE_W-1:0]    rspRate,
  output logic [7:0]           sigCode,
  output logic [7:0]           rsvTime,
  output logic [RATE_W-1:0]    topCck,
  output logic [RATE_W-1:0]    topOfdm,
  output logic                 anyOfdm
);
  localparam logic [RATE_W-1:0] FB_IDX = RATE_W'(FALLBACK);
  localparam logic [RATE_W-1:0] CCK_N  = RATE_W'(NUM_CCK);

  // eligible[i]: rate i is basic and not above the search start
  logic [NUM_RATES-1:0] eligible;
  genvar g;
  generate
    for (g = 0; g < NUM_RATES; g++) begin : g_elig
      assign eligible[g] = basicMap[g] && (RATE_W'(g) <= strobe.startIdx);
    end
  endgenerate

  logic [RATE_W-1:0] cckHit, ofdmHit, topC, topO, clampFb, nextRate;
  logic              anyO;

  always_comb begin
    cckHit  = '0;
    ofdmHit = FB_IDX;
    topC    = '0;
    topO    = FB_IDX;
    anyO    = 1'b0;
    // the CCK search stops above index 0, which is its own fallback
    for (int i = 1; i < NUM_CCK; i++)
      if (eligible[i]) cckHit = RATE_W'(i);
    for (int i = NUM_CCK; i < NUM_RATES; i++) begin
      if (eligible[i]) ofdmHit = RATE_W'(i);
      if (basicMap[i]) begin
        topO = RATE_W'(i);
        anyO = 1'b1;
      end
    end
    for (int i = 0; i < NUM_CCK; i++)
      if (basicMap[i]) topC = RATE_W'(i);
    clampFb = (strobe.startIdx > FB_IDX) ? FB_IDX : strobe.startIdx;
    if (!strobe.ofdmReq) nextRate = cckHit;
    else if (!anyO)      nextRate = clampFb;
    else                 nextRate = ofdmHit;
  end

  logic [7:0] encCode, encRsv;
  rsp_rate_enc #(
    .NUM_CCK(NUM_CCK), .NUM_RATES(NUM_RATES), .FALLBACK(FALLBACK)
  ) u_enc (
    .rateIdx(nextRate),
    .band5g (band5g),
    .code   (encCode),
    .rsv    (encRsv)
  );

  logic ofdmRsp;
  assign ofdmRsp = (nextRate >= CCK_N);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRate <= '0;
      sigCode <= '0;
      rsvTime <= '0;
      topCck  <= '0;
      topOfdm <= '0;
      anyOfdm <= 1'b0;
    end else if (strobe.capture) begin
      rspRate <= nextRate;
      sigCode <= ofdmRsp ? encCode : 8'd0;
      rsvTime <= ofdmRsp ? encRsv  : 8'd0;
      topCck  <= topC;
      topOfdm <= topO;
      anyOfdm <= anyO;
    end
  end

  // R1: results hold between requests
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rspRate) && $stable(sigCode) && $stable(topOfdm));
  // R3: a CCK request stays in the CCK group
  p_cck_group_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.ofdmReq) |=> (rspRate < CCK_N));
  // R3: a found CCK rate is basic
  p_cck_basic_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.ofdmReq) |=>
      (rspRate == '0) || (($past(basicMap) >> rspRate) & 1) != 0);
  // R5: an OFDM request stays in the OFDM group
  p_ofdm_group_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.ofdmReq) |=> (rspRate >= CCK_N));
  // R7: band nibble follows the band of the request
  p_band_nibble_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.ofdmReq) |=>
      (sigCode[7:4] == ($past(band5g) ? 4'h9 : 4'h8)));
  // R9: CCK responses carry no code
  p_cck_nocode_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.ofdmReq) |=> (sigCode == 8'd0 && rsvTime == 8'd0));
endmodule

// File: rtl/rsp_rate_picker.sv
module rsp_rate_picker
  import rsp_rate_pkg::*;
#(
  parameter int NUM_CCK   = 4,
  parameter int NUM_RATES = 12,
  parameter int FALLBACK  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [RATE_W-1:0]    reqRate,
  input  logic [NUM_RATES-1:0] basicMap,
  input  logic                 band5g,
  output logic                 rspValid,
  output logic [RATE_W-1:0]    rspRate,
  output logic [7:0]           sigCode,
  output logic [7:0]           rsvTime,
  output logic [RATE_W-1:0]    topCck,
  output logic [RATE_W-1:0]    topOfdm,
  output logic                 anyOfdm
);
  rateStrobe_t strobe;

  rsp_rate_ctrl #(.NUM_CCK(NUM_CCK), .NUM_RATES(NUM_RATES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqRate (reqRate),
    .strobe  (strobe),
    .rspValid(rspValid)
  );

  rsp_rate_dp #(
    .NUM_CCK(NUM_CCK), .NUM_RATES(NUM_RATES), .FALLBACK(FALLBACK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .basicMap(basicMap),
    .band5g  (band5g),
    .rspRate (rspRate),
    .sigCode (sigCode),
    .rsvTime (rsvTime),
    .topCck  (topCck),
    .topOfdm (topOfdm),
    .anyOfdm (anyOfdm)
  );
endmodule

// File: tb/rsp_rate_picker_test.sv
module rsp_rate_picker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {idx, map, band5g, expRate, expCode, expRsv}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd3,  12'h000, 1'b0, 4'd0,  8'h00, 8'd0},
    {4'd3,  12'h004, 1'b0, 4'd2,  8'h00, 8'd0},
    {4'd11, 12'h00F, 1'b1, 4'd8,  8'h99, 8'd28},
    {4'd5,  12'h003, 1'b0, 4'd5,  8'h8F, 8'd42},
    {4'd11, 12'h040, 1'b1, 4'd6,  8'h9A, 8'd32},
    {4'd5,  12'h800, 1'b1, 4'd8,  8'h99, 8'd28},
    {4'd10, 12'h410, 1'b0, 4'd10, 8'h88, 8'd30},
    {4'd4,  12'h010, 1'b1, 4'd4,  8'h9B, 8'd44},
    {4'd14, 12'h200, 1'b0, 4'd9,  8'h8D, 8'd30}
  };

  logic clk = 0, rstN = 0, reqValid = 0, band5g = 0;
  logic [3:0] reqRate = 0;
  logic [11:0] basicMap = 0;
  logic rspValid, anyOfdm;
  logic [3:0] rspRate, topCck, topOfdm;
  logic [7:0] sigCode, rsvTime;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_rate_picker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate),
    .basicMap(basicMap), .band5g(band5g), .rspValid(rspValid),
    .rspRate(rspRate), .sigCode(sigCode), .rsvTime(rsvTime),
    .topCck(topCck), .topOfdm(topOfdm), .anyOfdm(anyOfdm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // expected response from the requirements
  function automatic int mRate(input int idx, input logic [11:0] m);
    int s, r;
    logic anyO;
    s = (idx > 11) ? 11 : idx;
    anyO = |m[11:4];
    if (s < 4) begin
      r = 0;
      for (int i = 1; i <= s; i++) if (m[i]) r = i;
    end else if (!anyO) r = (s > 8) ? 8 : s;
    else begin
      r = 8;
      for (int i = 4; i <= s; i++) if (m[i]) r = i;
    end
    return r;
  endfunction

  function automatic int mCode(input int r, input logic b);
    int lo[8] = '{11, 15, 10, 14, 9, 13, 8, 12};
    if (r < 4) return 0;
    return (b ? 144 : 128) + lo[r-4];
  endfunction

  function automatic int mRsv(input int r, input logic b);
    int t[8] = '{44, 36, 32, 28, 28, 24, 24, 24};
    if (r < 4) return 0;
    return t[r-4] + (b ? 0 : 6);
  endfunction

  function automatic int mTopO(input logic [11:0] m);
    int r = 8;
    for (int i = 4; i < 12; i++) if (m[i]) r = i;
    return r;
  endfunction

  function automatic int mTopC(input logic [11:0] m);
    int r = 0;
    for (int i = 0; i < 4; i++) if (m[i]) r = i;
    return r;
  endfunction

  function automatic string rateTag(input int idx, input logic [11:0] m);
    if (idx > 11) return "R6";
    if (idx < 4) return "R3";
    if (m[11:4] == 0) return "R4";
    return "R5";
  endfunction

  // check outputs against the request applied one cycle earlier
  task automatic chkAll(input int idx, input logic [11:0] m, input logic b, input bit full);
    int r;
    r = mRate(idx, m);
    chk("R1 valid", int'(rspValid), 1);
    chk(rateTag(idx, m), int'(rspRate), r);
    chk(r < 4 ? "R9 code" : "R7 code", int'(sigCode), mCode(r, b));
    chk(r < 4 ? "R9 rsv" : "R8 rsv", int'(rsvTime), mRsv(r, b));
    if (full) begin
      chk("R10 topOfdm", int'(topOfdm), mTopO(m));
      chk("R10 topCck", int'(topCck), mTopC(m));
      chk("R10 anyOfdm", int'(anyOfdm), int'(|m[11:4]));
    end
  endtask

  task automatic issue(input int idx, input logic [11:0] m, input logic b);
    reqValid = 1; reqRate = 4'(idx); basicMap = m; band5g = b;
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pIdx; logic [11:0] pMap; logic pBand; bit pend;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 valid", int'(rspValid), 0);
    chk("R2 rate", int'(rspRate), 0);
    chk("R2 code", int'(sigCode), 0);
    chk("R2 rsv", int'(rsvTime), 0);
    chk("R2 tops", int'({topCck, topOfdm, anyOfdm}), 0);
    rstN = 1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      issue(int'(VEC[v][36:33]), VEC[v][32:21], VEC[v][20]);
      @(negedge clk);
      reqValid = 0;
      chk("R1 valid", int'(rspValid), 1);
      chk(rateTag(int'(VEC[v][36:33]), VEC[v][32:21]), int'(rspRate), int'(VEC[v][19:16]));
      chk("R7 code", int'(sigCode), int'(VEC[v][15:8]));
      chk("R8 rsv", int'(rsvTime), int'(VEC[v][7:0]));
    end

    // R1 hold: change inputs without strobe
    issue(9, 12'h010, 1'b1);
    reqValid = 0;
    @(negedge clk);
    chk("R1 idle valid", int'(rspValid), 0);
    chk("R1 hold rate", int'(rspRate), 9);
    chk("R1 hold code", int'(sigCode), 8'h8D);

    // R6 directed: indices 12..15 equal index 11
    for (int k = 12; k < 16; k++) begin
      issue(k, 12'h0A0, 1'b1);
      @(negedge clk);
      reqValid = 0;
      chkAll(k, 12'h0A0, 1'b1, 1);
      chk("R6 same as 11", int'(rspRate), mRate(11, 12'h0A0));
    end

    // exhaustive back-to-back sweep
    pend = 0; pIdx = 0; pMap = 0; pBand = 0;
    for (int b = 0; b < 2; b++)
      for (int idx = 0; idx < 12; idx++)
        for (int m = 0; m < 4096; m++) begin
          issue(idx, 12'(m), b[0]);
          @(negedge clk);
          chkAll(idx, 12'(m), b[0], 1);
        end
    reqValid = 0;
    @(negedge clk);
    chk("R1 drop", int'(rspValid), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule